// File: doc/BRIEF.md
# Clock/Calendar Serial Pointer Slave

This block is the two-wire serial slave for a clock/calendar register file. After a START it takes a 7-bit device address. The upper five bits of that address are fixed by a parameter and the lower two come from strap pins, so up to four devices can share one bus. In a write, the next byte is a pointer byte. Its upper nibble carries a 3-bit command code and its lower nibble carries a 3-bit register index. Under the "execute" command, any data bytes that follow are written into the time or alarm bank. Under the other codes, the block emits a one-cycle command pulse to the timekeeping logic.

In a read, the block returns either a register byte, with the unused upper bits forced to zero, or a flag status byte. Which one it returns depends on the stored command code. SCL and SDA are sampled on a fast system clock. SDA is driven only through an active-high pull-down enable.

The pointer is kept between transactions. A read that comes straight after the address byte therefore uses whatever pointer was last accepted. The register index steps through its two low bits after every transferred data byte, and bit 2 (the bank) is never changed by this stepping.

Top module: `clkcal_i2c_slave`

## Requirements
- R1: The device address is {ADDR_HI, strap[1:0]}, with R/W in bit 0 of the first byte. A matching address is acknowledged. Any other address is not acknowledged, and SDA stays released until the next START.
- R2: A pointer byte is not acknowledged when bit 7 is 1, when bits 6:4 equal 111, or when bits 6:4 equal 000 with bit 3 set. All other pointer bytes are acknowledged and stored (command = bits 6:4, index = bits 2:0).
- R3: A written data byte is acknowledged only while the stored command is 000. Each acknowledged data byte gives a one-cycle wr_en with wr_idx equal to the current index and wr_data equal to the byte.
- R4: After each data byte, written or read, under command 000, index bits 1:0 advance by one modulo 4 and bit 2 is kept (3→0, 7→4).
- R5: An accepted pointer with command 010, 011, 100, 101 or 110 gives a single-cycle pulse on presc_rst, time_adj, noda_clr, noda_set or comp_clr respectively. At most one pulse or strobe is active in any cycle.
- R6: An accepted pointer with command 000 gives a single-cycle powf_clr pulse.
- R7: Under command 000, a read returns rd_raw masked by index bits 1:0: 00 → bits 5:0, 01 → bits 6:0, 10 → bits 5:0, 11 → bits 4:0. All other bits read as zero.
- R8: Under any stored command other than 000, a read returns {000, lvl_min, lvl_sec, flag_noda, flag_comp, flag_powf}.
- R9: The stored command and index survive STOP and reset only with rst_n (reset value 0, index 0). A read directly after the address byte uses them.
- R10: When the master does not acknowledge a read byte, SDA is released and stays released for any further clocks until START or STOP.
- R11: sda_oe changes only while the synchronised SCL is low, and it is low after reset.
- R12: A START received at any point, including mid-byte, restarts address reception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock, much faster than SCL |
| rst_n | input | 1 | synchronous active-low reset |
| scl_i | input | 1 | serial clock line level |
| sda_i | input | 1 | serial data line level |
| sda_oe | output | 1 | 1 pulls SDA low |
| strap | input | 2 | low two device address bits |
| rd_sel | output | 3 | current register index (bank, 2-bit offset) |
| rd_raw | input | 7 | register content at rd_sel |
| lvl_min | input | 1 | minute pulse level for status byte |
| lvl_sec | input | 1 | second pulse level for status byte |
| flag_noda | input | 1 | no-date flag for status byte |
| flag_comp | input | 1 | alarm match flag for status byte |
| flag_powf | input | 1 | power-fail flag for status byte |
| wr_en | output | 1 | register write strobe |
| wr_idx | output | 3 | register index of the write |
| wr_data | output | 8 | written byte |
| presc_rst | output | 1 | reset prescaler and seconds pulse |
| time_adj | output | 1 | time adjust with carry pulse |
| noda_clr | output | 1 | clear no-date flag pulse |
| noda_set | output | 1 | set no-date flag pulse |
| comp_clr | output | 1 | clear alarm flag pulse |
| powf_clr | output | 1 | clear power-fail flag pulse |

## Verification
The bench builds the block with its default parameters: the five fixed address bits set to 11010 and two synchroniser stages. It moves the strap value between 10 and 01 partway through, so that the address match follows the pins and a formerly valid address is then refused. With a 10-cycle quarter bit, every command code and both register banks can be exercised, including the index wrap at 3 and at 7. Mid-byte restarts and reads past a master NACK also fit in a short run.

// File: rtl/clkcal_pkg.sv
// Shared types for the clock/calendar serial slave.
// Assumes a byte-oriented two-wire bus with MSB-first data.
package clkcal_pkg;

    // byte sequencer states
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK,
        ST_TX,
        ST_RACK,
        ST_RNEXT,
        ST_SKIP
    } link_st_t;

    // which byte of a write is being received
    typedef enum logic [1:0] {
        BK_ADDR,
        BK_PTR,
        BK_DATA
    } byte_kind_t;

    // command codes held in pointer bits 6:4
    localparam logic [2:0] CTL_EXEC  = 3'd0;
    localparam logic [2:0] CTL_STAT  = 3'd1;
    localparam logic [2:0] CTL_PRESC = 3'd2;
    localparam logic [2:0] CTL_TADJ  = 3'd3;
    localparam logic [2:0] CTL_NCLR  = 3'd4;
    localparam logic [2:0] CTL_NSET  = 3'd5;
    localparam logic [2:0] CTL_CCLR  = 3'd6;
    localparam logic [2:0] CTL_BAD   = 3'd7;

    // one-cycle command pulses toward the timekeeping logic
    typedef struct packed {
        logic presc;
        logic tadj;
        logic nclr;
        logic nset;
        logic cclr;
        logic pclr;
    } cmd_t;

endpackage

// File: rtl/cc_line_sense.sv
// Synchronises SCL and SDA into the system clock domain and derives
// edge and START/STOP events from the synchronised levels.
// Assumes the system clock is several times faster than SCL.
module cc_line_sense #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_evt,
    output logic stop_evt
);
    logic [SYNC_STAGES-1:0] scl_pipe;
    logic [SYNC_STAGES-1:0] sda_pipe;
    logic scl_q;
    logic sda_q;

    generate
        if (SYNC_STAGES > 1) begin : g_multi
            // shift the raw lines through the synchroniser chain
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    scl_pipe <= '1;
                    sda_pipe <= '1;
                end else begin
                    scl_pipe <= {scl_pipe[SYNC_STAGES-2:0], scl_i};
                    sda_pipe <= {sda_pipe[SYNC_STAGES-2:0], sda_i};
                end
            end
        end else begin : g_single
            // single capture stage
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    scl_pipe <= '1;
                    sda_pipe <= '1;
                end else begin
                    scl_pipe <= scl_i;
                    sda_pipe <= sda_i;
                end
            end
        end
    endgenerate

    assign scl_s = scl_pipe[SYNC_STAGES-1];
    assign sda_s = sda_pipe[SYNC_STAGES-1];

    // remember the previous synchronised levels for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    assign scl_rise  =  scl_s & ~scl_q;
    assign scl_fall  = ~scl_s &  scl_q;
    assign start_evt =  scl_s &  scl_q & ~sda_s &  sda_q;
    assign stop_evt  =  scl_s &  scl_q &  sda_s & ~sda_q;

endmodule

// File: rtl/cc_ptr_policy.sv
// Combinational policy: pointer acceptance, command decode, data
// acceptance and read byte formatting.
// Assumes the stored command/index come from registers (no loops).
module cc_ptr_policy
    import clkcal_pkg::*;
(
    input  logic [4:0] ptr_hi,     // received pointer bits 7:3
    input  logic [2:0] cur_ctrl,
    input  logic [1:0] cur_off,
    input  logic [6:0] rd_raw,
    input  logic       lvl_min,
    input  logic       lvl_sec,
    input  logic       flag_noda,
    input  logic       flag_comp,
    input  logic       flag_powf,
    output logic       ptr_ok,
    output cmd_t       ptr_cmd,
    output logic       data_ok,
    output logic [7:0] tx_byte
);
    logic [2:0] new_ctrl;
    assign new_ctrl = ptr_hi[3:1];

    // decide whether a received pointer byte is accepted
    always_comb begin
        ptr_ok = 1'b1;
        if (ptr_hi[4])                            ptr_ok = 1'b0;
        if (new_ctrl == CTL_BAD)                  ptr_ok = 1'b0;
        if (new_ctrl == CTL_EXEC && ptr_hi[0])    ptr_ok = 1'b0;
    end

    // map the new command code to its pulse
    always_comb begin
        ptr_cmd = '0;
        unique case (new_ctrl)
            CTL_EXEC:  ptr_cmd.pclr  = 1'b1;
            CTL_PRESC: ptr_cmd.presc = 1'b1;
            CTL_TADJ:  ptr_cmd.tadj  = 1'b1;
            CTL_NCLR:  ptr_cmd.nclr  = 1'b1;
            CTL_NSET:  ptr_cmd.nset  = 1'b1;
            CTL_CCLR:  ptr_cmd.cclr  = 1'b1;
            default:   ptr_cmd = '0;
        endcase
    end

    assign data_ok = (cur_ctrl == CTL_EXEC);

    // format the next byte to shift out
    always_comb begin
        if (cur_ctrl == CTL_EXEC) begin
            unique case (cur_off)
                2'd1:    tx_byte = {1'b0,  rd_raw[6:0]};
                2'd3:    tx_byte = {3'b000, rd_raw[4:0]};
                default: tx_byte = {2'b00, rd_raw[5:0]};
            endcase
        end else begin
            tx_byte = {3'b000, lvl_min, lvl_sec, flag_noda, flag_comp, flag_powf};
        end
    end

endmodule

// File: rtl/cc_link_fsm.sv
// Byte sequencer: address match, pointer capture, write strobes,
// command pulses and read shifting, with the open-drain enable.
// Assumes events from cc_line_sense; SDA enable changes after SCL falls.
module cc_link_fsm
    import clkcal_pkg::*;
#(
    parameter logic [4:0] ADDR_HI = 5'b11010
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sda_s,
    input  logic       scl_rise,
    input  logic       scl_fall,
    input  logic       start_evt,
    input  logic       stop_evt,
    input  logic [1:0] strap,
    input  logic       ptr_ok,
    input  cmd_t       ptr_cmd,
    input  logic       data_ok,
    input  logic [7:0] tx_byte,
    output logic [7:0] rx_sh,
    output logic [2:0] cur_ctrl,
    output logic [2:0] cur_idx,
    output logic       sda_oe,
    output logic       wr_en,
    output logic [2:0] wr_idx,
    output logic [7:0] wr_data,
    output cmd_t       cmd_q
);
    localparam int BITS = 8;
    localparam int CW   = $clog2(BITS + 1);
    localparam logic [CW-1:0] LAST = CW'(BITS);

    link_st_t   st;
    byte_kind_t kind;
    logic [CW-1:0] cnt;
    logic       rnw;
    logic       addr_hit;
    logic [2:0] next_idx;

    assign addr_hit = (rx_sh[7:1] == {ADDR_HI, strap});
    assign next_idx = {cur_idx[2], cur_idx[1:0] + 2'd1};

    // main sequencer with bus-event priority over byte progress
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ST_IDLE;
            kind     <= BK_ADDR;
            cnt      <= '0;
            rnw      <= 1'b0;
            rx_sh    <= '0;
            cur_ctrl <= CTL_EXEC;
            cur_idx  <= '0;
            sda_oe   <= 1'b0;
            wr_en    <= 1'b0;
            wr_idx   <= '0;
            wr_data  <= '0;
            cmd_q    <= '0;
        end else begin
            wr_en <= 1'b0;
            cmd_q <= '0;
            if (start_evt) begin
                st     <= ST_RX;
                kind   <= BK_ADDR;
                cnt    <= '0;
                sda_oe <= 1'b0;
            end else if (stop_evt) begin
                st     <= ST_IDLE;
                cnt    <= '0;
                sda_oe <= 1'b0;
            end else begin
                unique case (st)
                    ST_RX: begin
                        if (scl_rise) begin
                            rx_sh <= {rx_sh[6:0], sda_s};
                            cnt   <= cnt + 1'b1;
                        end else if (scl_fall && cnt == LAST) begin
                            cnt <= '0;
                            unique case (kind)
                                BK_ADDR: begin
                                    if (addr_hit) begin
                                        sda_oe <= 1'b1;
                                        rnw    <= rx_sh[0];
                                        st     <= ST_ACK;
                                    end else begin
                                        st <= ST_SKIP;
                                    end
                                end
                                BK_PTR: begin
                                    if (ptr_ok) begin
                                        sda_oe   <= 1'b1;
                                        st       <= ST_ACK;
                                        cur_ctrl <= rx_sh[6:4];
                                        cur_idx  <= rx_sh[2:0];
                                        cmd_q    <= ptr_cmd;
                                    end else begin
                                        st <= ST_SKIP;
                                    end
                                end
                                default: begin
                                    if (data_ok) begin
                                        sda_oe  <= 1'b1;
                                        st      <= ST_ACK;
                                        wr_en   <= 1'b1;
                                        wr_idx  <= cur_idx;
                                        wr_data <= rx_sh;
                                        cur_idx <= next_idx;
                                    end else begin
                                        st <= ST_SKIP;
                                    end
                                end
                            endcase
                        end
                    end
                    ST_ACK: begin
                        if (scl_fall) begin
                            if (kind == BK_ADDR && rnw) begin
                                st     <= ST_TX;
                                rx_sh  <= tx_byte;
                                sda_oe <= ~tx_byte[7];
                                cnt    <= CW'(1);
                            end else begin
                                sda_oe <= 1'b0;
                                st     <= ST_RX;
                                cnt    <= '0;
                                kind   <= (kind == BK_ADDR) ? BK_PTR : BK_DATA;
                            end
                        end
                    end
                    ST_TX: begin
                        if (scl_fall) begin
                            if (cnt == LAST) begin
                                sda_oe <= 1'b0;
                                st     <= ST_RACK;
                                if (cur_ctrl == CTL_EXEC) cur_idx <= next_idx;
                            end else begin
                                rx_sh  <= {rx_sh[6:0], 1'b0};
                                sda_oe <= ~rx_sh[6];
                                cnt    <= cnt + 1'b1;
                            end
                        end
                    end
                    ST_RACK: begin
                        if (scl_rise) st <= sda_s ? ST_SKIP : ST_RNEXT;
                    end
                    ST_RNEXT: begin
                        if (scl_fall) begin
                            st     <= ST_TX;
                            rx_sh  <= tx_byte;
                            sda_oe <= ~tx_byte[7];
                            cnt    <= CW'(1);
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/clkcal_i2c_slave.sv
// Top of the clock/calendar serial slave: line sensing, byte
// sequencing and pointer policy wired together.
// Assumes an external pull-up on SDA; sda_oe=1 pulls the line low.
module clkcal_i2c_slave
    import clkcal_pkg::*;
#(
    parameter logic [4:0] ADDR_HI     = 5'b11010,
    parameter int         SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe,
    input  logic [1:0] strap,
    output logic [2:0] rd_sel,
    input  logic [6:0] rd_raw,
    input  logic       lvl_min,
    input  logic       lvl_sec,
    input  logic       flag_noda,
    input  logic       flag_comp,
    input  logic       flag_powf,
    output logic       wr_en,
    output logic [2:0] wr_idx,
    output logic [7:0] wr_data,
    output logic       presc_rst,
    output logic       time_adj,
    output logic       noda_clr,
    output logic       noda_set,
    output logic       comp_clr,
    output logic       powf_clr
);
    logic scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt;
    logic ptr_ok, data_ok;
    cmd_t ptr_cmd, cmd_q;
    logic [7:0] tx_byte, rx_sh;
    logic [2:0] cur_ctrl, cur_idx;

    cc_line_sense #(.SYNC_STAGES(SYNC_STAGES)) u_sense (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_evt(start_evt), .stop_evt(stop_evt)
    );

    cc_ptr_policy u_policy (
        .ptr_hi(rx_sh[7:3]), .cur_ctrl(cur_ctrl), .cur_off(cur_idx[1:0]),
        .rd_raw(rd_raw), .lvl_min(lvl_min), .lvl_sec(lvl_sec),
        .flag_noda(flag_noda), .flag_comp(flag_comp), .flag_powf(flag_powf),
        .ptr_ok(ptr_ok), .ptr_cmd(ptr_cmd), .data_ok(data_ok), .tx_byte(tx_byte)
    );

    cc_link_fsm #(.ADDR_HI(ADDR_HI)) u_fsm (
        .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_evt(start_evt), .stop_evt(stop_evt),
        .strap(strap), .ptr_ok(ptr_ok), .ptr_cmd(ptr_cmd), .data_ok(data_ok),
        .tx_byte(tx_byte), .rx_sh(rx_sh), .cur_ctrl(cur_ctrl),
        .cur_idx(cur_idx), .sda_oe(sda_oe), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .cmd_q(cmd_q)
    );

    assign rd_sel    = cur_idx;
    assign presc_rst = cmd_q.presc;
    assign time_adj  = cmd_q.tadj;
    assign noda_clr  = cmd_q.nclr;
    assign noda_set  = cmd_q.nset;
    assign comp_clr  = cmd_q.cclr;
    assign powf_clr  = cmd_q.pclr;

endmodule

// Property checker for clkcal_i2c_slave, attached by bind below.
// Assumes the stored command code is visible as ptr_ctrl.
module clkcal_i2c_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       sda_oe,
    input logic       scl_s,
    input logic [2:0] ptr_ctrl,
    input logic       wr_en,
    input logic [2:0] wr_idx,
    input logic [2:0] rd_sel,
    input logic       presc_rst,
    input logic       time_adj,
    input logic       noda_clr,
    input logic       noda_set,
    input logic       comp_clr,
    input logic       powf_clr
);
    logic any_cmd;
    assign any_cmd = presc_rst | time_adj | noda_clr | noda_set | comp_clr | powf_clr;

    a_r3_wr_needs_exec: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> ptr_ctrl == 3'd0);

    a_r4_idx_no_carry: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> rd_sel == {wr_idx[2], wr_idx[1:0] + 2'd1});

    a_r5_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({presc_rst, time_adj, noda_clr, noda_set, comp_clr, powf_clr, wr_en}));

    a_r5_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
        any_cmd |=> !any_cmd);

    a_r5_presc_code: assert property (@(posedge clk) disable iff (!rst_n)
        presc_rst |-> ptr_ctrl == 3'd2);

    a_r5_nset_code: assert property (@(posedge clk) disable iff (!rst_n)
        noda_set |-> ptr_ctrl == 3'd5);

    a_r6_powf_exec: assert property (@(posedge clk) disable iff (!rst_n)
        powf_clr |-> ptr_ctrl == 3'd0);

    a_r11_oe_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> !scl_s);

endmodule

bind clkcal_i2c_slave clkcal_i2c_checker u_chk (
    .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe), .scl_s(scl_s),
    .ptr_ctrl(cur_ctrl), .wr_en(wr_en), .wr_idx(wr_idx), .rd_sel(rd_sel),
    .presc_rst(presc_rst), .time_adj(time_adj), .noda_clr(noda_clr),
    .noda_set(noda_set), .comp_clr(comp_clr), .powf_clr(powf_clr)
);

// File: tb/sim_clkcal_i2c_slave.sv
`timescale 1ns/1ps
module sim_clkcal_i2c_slave;
    localparam int Q = 10;
    localparam logic [4:0] HI = 5'b11010;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic [1:0] strap = 2'b10;
    logic lvl_min = 0, lvl_sec = 0, flag_noda = 0, flag_comp = 0, flag_powf = 0;
    logic sda_oe, wr_en, presc_rst, time_adj, noda_clr, noda_set, comp_clr, powf_clr;
    logic [2:0] rd_sel, wr_idx;
    logic [7:0] wr_data;
    logic [7:0] rf [8];
    logic sda_line;
    logic [6:0] rd_raw;

    always #2.5 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;
    assign rd_raw = rf[rd_sel][6:0];

    clkcal_i2c_slave u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
        .strap(strap), .rd_sel(rd_sel), .rd_raw(rd_raw), .lvl_min(lvl_min),
        .lvl_sec(lvl_sec), .flag_noda(flag_noda), .flag_comp(flag_comp),
        .flag_powf(flag_powf), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .presc_rst(presc_rst), .time_adj(time_adj), .noda_clr(noda_clr),
        .noda_set(noda_set), .comp_clr(comp_clr), .powf_clr(powf_clr)
    );

    // bench register file fed by the write strobe
    always @(posedge clk) begin
        if (!rst_n) for (int i = 0; i < 8; i++) rf[i] <= 8'h00;
        else if (wr_en) rf[wr_idx] <= wr_data;
    end

    int n_tests = 0, n_fail = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    // scoreboard: kind 0 write ({idx,data}), 1 presc, 2 tadj, 3 nclr,
    // 4 nset, 5 cclr, 6 pclr
    typedef struct { int kind; int val; string req; } exp_t;
    exp_t q[$];

    task automatic push(input int k, input int v, input string req);
        exp_t e;
        e.kind = k; e.val = v; e.req = req;
        q.push_back(e);
    endtask

    task automatic observe(input int k, input int v);
        exp_t e;
        if (q.size() == 0) chk(1'b0, "R5 unexpected strobe", k * 4096 + v, -1);
        else begin
            e = q.pop_front();
            chk(e.kind == k && e.val == v, e.req, k * 4096 + v, e.kind * 4096 + e.val);
        end
    endtask

    // monitor: pops one expectation per observed strobe
    always @(negedge clk) begin
        if (rst_n) begin
            if (wr_en)     observe(0, {21'd0, wr_idx, wr_data});
            if (presc_rst) observe(1, 0);
            if (time_adj)  observe(2, 0);
            if (noda_clr)  observe(3, 0);
            if (noda_set)  observe(4, 0);
            if (comp_clr)  observe(5, 0);
            if (powf_clr)  observe(6, 0);
        end
    end

    task automatic waitq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1; waitq(Q); scl_m = 1; waitq(Q);
        sda_m = 0; waitq(Q); scl_m = 0; waitq(Q);
    endtask

    task automatic bus_stop();
        sda_m = 0; waitq(Q); scl_m = 1; waitq(Q); sda_m = 1; waitq(Q);
    endtask

    task automatic send_bits(input int n, input logic [7:0] b);
        for (int i = 7; i > 7 - n; i--) begin
            sda_m = b[i]; waitq(Q); scl_m = 1; waitq(2 * Q); scl_m = 0; waitq(Q);
        end
    endtask

    task automatic wr_byte(input logic [7:0] b, input bit exp_ack, input string req);
        logic ack;
        send_bits(8, b);
        sda_m = 1; waitq(Q); scl_m = 1; waitq(Q);
        ack = ~sda_line;
        waitq(Q); scl_m = 0; waitq(Q);
        chk(ack == exp_ack, req, ack, exp_ack);
    endtask

    task automatic rd_byte(input logic [7:0] exp, input bit mack, input string req);
        logic [7:0] b;
        for (int i = 7; i >= 0; i--) begin
            sda_m = 1; waitq(Q); scl_m = 1; waitq(Q);
            b[i] = sda_line;
            waitq(Q); scl_m = 0; waitq(Q);
        end
        sda_m = mack ? 1'b0 : 1'b1;
        waitq(Q); scl_m = 1; waitq(2 * Q); scl_m = 0; waitq(Q);
        sda_m = 1;
        chk(b == exp, req, b, exp);
    endtask

    logic [7:0] adw, adr;

    initial begin
        adw = {HI, 2'b10, 1'b0};
        adr = {HI, 2'b10, 1'b1};
        waitq(6);
        rst_n = 1;
        waitq(6);
        chk(sda_oe == 1'b0, "R11 reset releases SDA", sda_oe, 0);
        chk(rd_sel == 3'd0, "R9 reset index", rd_sel, 0);

        // R1: foreign strap value is refused
        bus_start(); wr_byte({HI, 2'b01, 1'b0}, 0, "R1 foreign address nack"); bus_stop();

        // R3/R4/R6: time bank writes with wrap
        push(6, 0, "R6 powf_clr on exec pointer");
        push(0, 'h0E3, "R3 write idx0"); push(0, 'h1D9, "R3 write idx1");
        push(0, 'h2F1, "R3 write idx2"); push(0, 'h3F2, "R3 write idx3");
        push(0, 'h0E3, "R4 wrap 3 to 0");
        bus_start(); wr_byte(adw, 1, "R1 address ack"); wr_byte(8'h00, 1, "R2 exec ptr ack");
        wr_byte(8'hE3, 1, "R3 data ack"); wr_byte(8'hD9, 1, "R3 data ack");
        wr_byte(8'hF1, 1, "R3 data ack"); wr_byte(8'hF2, 1, "R3 data ack");
        wr_byte(8'hE3, 1, "R3 data ack"); bus_stop();

        // R4: alarm bank wrap 7 to 4
        push(6, 0, "R6 powf_clr");
        push(0, 'h7D4, "R3 write idx7"); push(0, 'h4A1, "R4 wrap 7 to 4");
        push(0, 'h5B2, "R4 idx5"); push(0, 'h6C3, "R4 idx6");
        bus_start(); wr_byte(adw, 1, "R1"); wr_byte(8'h07, 1, "R2 ptr 07 ack");
        wr_byte(8'hD4, 1, "R3"); wr_byte(8'hA1, 1, "R3");
        wr_byte(8'hB2, 1, "R3"); wr_byte(8'hC3, 1, "R3"); bus_stop();

        // R2: refused pointer bytes
        bus_start(); wr_byte(adw, 1, "R1"); wr_byte(8'h80, 0, "R2 bit7 nack"); bus_stop();
        bus_start(); wr_byte(adw, 1, "R1"); wr_byte(8'h08, 0, "R2 exec bit3 nack"); bus_stop();
        bus_start(); wr_byte(adw, 1, "R1"); wr_byte(8'h70, 0, "R2 code 111 nack"); bus_stop();

        // R5: command pulses, data refused under non-exec codes
        for (int c = 2; c <= 6; c++) begin
            push(c - 1, 0, "R5 command pulse");
            bus_start(); wr_byte(adw, 1, "R1");
            wr_byte({1'b0, 3'(c), 4'h0}, 1, "R2 command ptr ack");
            wr_byte(8'h12, 0, "R3 data nack under non-exec");
            bus_stop();
        end

        // R8/R9: status byte from stored command 110, direct read
        lvl_min = 1; lvl_sec = 0; flag_noda = 1; flag_comp = 0; flag_powf = 1;
        bus_start(); wr_byte(adr, 1, "R1"); rd_byte(8'h15, 0, "R8 R9 status direct read"); bus_stop();
        lvl_min = 0; lvl_sec = 1; flag_noda = 0; flag_comp = 1; flag_powf = 0;
        bus_start(); wr_byte(adw, 1, "R1"); wr_byte(8'h10, 1, "R2 status ptr"); bus_stop();
        bus_start(); wr_byte(adr, 1, "R1"); rd_byte(8'h0A, 0, "R8 status byte"); bus_stop();

        // R7/R10: masked time bank reads, then clocks after NACK
        push(6, 0, "R6 powf_clr");
        bus_start(); wr_byte(adw, 1, "R1"); wr_byte(8'h00, 1, "R2");
        bus_start(); wr_byte(adr, 1, "R1 read address");
        rd_byte(8'h23, 1, "R7 hours mask"); rd_byte(8'h59, 1, "R7 minutes mask");
        rd_byte(8'h31, 1, "R7 days mask");  rd_byte(8'h12, 0, "R7 months mask");
        rd_byte(8'hFF, 0, "R10 released after nack");
        bus_stop();

        // R4/R7: alarm reads wrapping 7 to 4
        push(6, 0, "R6 powf_clr");
        bus_start(); wr_byte(adw, 1, "R1"); wr_byte(8'h06, 1, "R2");
        bus_start(); wr_byte(adr, 1, "R1");
        rd_byte(8'h03, 1, "R7 alarm days"); rd_byte(8'h14, 1, "R7 alarm months");
        rd_byte(8'h21, 0, "R4 read wrap to idx4");
        bus_stop();

        // R9: stored exec pointer, index now 5
        bus_start(); wr_byte(adr, 1, "R1"); rd_byte(8'h32, 0, "R9 stored pointer read"); bus_stop();

        // R12: START mid-byte restarts address reception
        push(4, 0, "R12 command after restart");
        bus_start(); send_bits(4, 8'hA0);
        bus_start(); wr_byte(adw, 1, "R12 address after restart");
        wr_byte(8'h50, 1, "R12 ptr ack"); bus_stop();

        // R1: address follows the strap pins
        strap = 2'b01;
        push(3, 0, "R5 noda_clr");
        bus_start(); wr_byte({HI, 2'b01, 1'b0}, 1, "R1 new strap ack");
        wr_byte(8'h40, 1, "R2"); bus_stop();
        bus_start(); wr_byte(adw, 0, "R1 old strap nack"); bus_stop();

        waitq(20);
        chk(q.size() == 0, "R5 all expected strobes seen", q.size(), 0);
        chk(sda_oe == 1'b0, "R11 idle SDA released", sda_oe, 0);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog R12 act=hung exp=finished");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule